// File: doc/BRIEF.md
# Multichannel Converter Word Framer

This block sits between a DSP-facing pin bus and the parallel converter words of N channels. It runs from one master clock. It divides that clock by two to make a bit clock and drives the bit clock out. It also drives a shared square-wave start-of-word strobe. For every channel it collects transmit (DAC) words from a two-line input lane and shifts receive (ADC) words out on a one-line output lane.

The receive lane has two rates. At full rate a 16-bit ADC word takes 16 bit-clock cycles and two DAC words arrive per strobe period. At half rate each receive bit is held for two bit-clock cycles, so a word takes 32 cycles and four DAC words arrive per strobe period. Receive words and transmit words can each be treated as two's complement or as offset binary. One setting covers all receive channels and one setting covers all transmit channels.

After reset the framer starts a clean frame on the first bit-clock rising edge, so it is aligned from the first complete frame. The bit-clock edges are modelled as enables in the master-clock domain.

Top module: `conv_word_framer`

## Requirements
- R1: While `rst_n` is low (sampled on the clock), `bit_clk`, `wclk`, every `rx_lane` bit and `dac_valid` are 0. From the first clock edge with `rst_n` high, `bit_clk` toggles on every `clk` rising edge. The edge on which it goes to 1 is a bit-clock rising edge and the edge on which it goes to 0 is a bit-clock falling edge.
- R2: The first bit-clock rising edge after reset starts a frame. On that edge `wclk` goes to 1 and each `rx_lane` bit shows bit 15 of its channel's word.
- R3: `wclk` changes only on bit-clock rising edges. It is 1 for the first half of each frame and 0 for the second half. A frame is 16 bit-clock cycles at full rate (`rate_half`=0) and 32 at half rate (`rate_half`=1).
- R4: At full rate, `rx_lane[c]` shows the bits of channel c's word from bit 15 down to bit 0, one bit per bit-clock cycle, and changes only on bit-clock rising edges.
- R5: At half rate, each receive bit stays on the lane for two bit-clock cycles. Bit 15 is shown in cycles 0 and 1 of the frame.
- R6: `adc_words[16c+15:16c]` is captured only on the frame-start edge. A change to it later in the frame has no effect on the lane until the next frame.
- R7: `rate_half` and `rx_fmt_ob` are captured only on the frame-start edge. A change to either one inside a frame does not alter that frame's strobe length or lane data.
- R8: `tx_lane[2c+1]` carries bits 15..8 and `tx_lane[2c]` carries bits 7..0 of channel c's DAC word, MSB first. Each bit is sampled on the bit-clock falling edge. DAC words occupy 8 bit-clock cycles each, starting at the frame start, so a frame holds two words at full rate and four at half rate.
- R9: `dac_valid` is high for exactly one `clk` cycle, right after the falling edge that samples the eighth bit pair of a word. At that point `dac_words[16c+15:16c]` holds the assembled word, and it stays there until the next word completes.
- R10: With `rx_fmt_ob`=1, bit 15 of every outgoing receive word is inverted (two's complement to offset binary). With 0 the word goes out unchanged.
- R11: With `tx_fmt_ob`=1, bit 15 of every assembled DAC word is inverted (offset binary to two's complement). The setting is taken when the word completes.
- R12: Each channel's lanes and words are independent: a channel's data appears only on that channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_half | input | 1 | 1 selects half-rate receive framing |
| rx_fmt_ob | input | 1 | 1 selects offset binary on receive lanes |
| tx_fmt_ob | input | 1 | 1 selects offset binary on transmit lanes |
| tx_lane | input | 2*NCH | Transmit lines; bit 2c+1 is the high-byte line of channel c |
| adc_words | input | 16*NCH | Parallel ADC words, channel c at bits 16c+15:16c |
| bit_clk | output | 1 | Master clock divided by two |
| wclk | output | 1 | Start-of-word strobe, 50% duty |
| rx_lane | output | NCH | Receive line per channel |
| dac_words | output | 16*NCH | Assembled DAC words, channel c at bits 16c+15:16c |
| dac_valid | output | 1 | One-cycle strobe when new DAC words are ready |

## Verification
If the frame counter is wrong, the strobe's high time or period is off within the first frame. The same fault also shifts every receive bit position and splits the DAC words at the wrong bit pair, so `dac_words` and the lanes disagree within 8 to 32 bit-clock cycles. A wrong bit-clock phase swaps capture and launch edges, which shows as shifted or doubled lane bits on the very first word. Mode or format state that is captured at the wrong time shows only when an input changes mid-frame. That is why the stimulus flips those inputs inside frames and checks the lanes through the rest of the frame.

// File: rtl/cwf_pkg.sv
// Shared definitions for the converter word framer.
// Assumes: converter words are 16 bits by default; modules may override.
package cwf_pkg;
    localparam int CWF_WORD_W = 16;

    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } cwf_rate_t;
endpackage

// File: rtl/cwf_timing.sv
// Frame timing: divides the master clock by two, counts bit-clock cycles
// within a frame, drives the start-of-word strobe, and issues the enables
// that the lane modules use in place of bit-clock edges.
// Assumes: rate mode is stable only at frame starts; it is captured there.
module cwf_timing
    import cwf_pkg::*;
#(
    parameter int WORD_W = CWF_WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rate_half,
    output logic                          bit_clk,
    output logic                          wclk,
    output logic                          frame_start,
    output logic                          rx_shift,
    output logic                          tx_sample,
    output logic                          tx_done
);
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(2 * WORD_W);
    localparam int POS_W  = $clog2(HALF_W);
    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(2 * WORD_W - 1);
    localparam logic [CNT_W-1:0] HIGH_FULL = CNT_W'(WORD_W / 2);
    localparam logic [CNT_W-1:0] HIGH_HALF = CNT_W'(WORD_W);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(HALF_W - 1);

    logic             bclk_q;
    logic             started_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    cwf_rate_t        mode_q;
    logic             wclk_q;
    logic             rise_en;
    logic             fall_en;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] high_lim;

    // Edge enables: the edge where bclk_q goes high is a bit-clock rise.
    always_comb begin
        rise_en  = ~bclk_q;
        fall_en  = bclk_q;
        last_cnt = (mode_q == RATE_HALF) ? LAST_HALF : LAST_FULL;
        high_lim = (mode_q == RATE_HALF) ? HIGH_HALF : HIGH_FULL;
        cnt_nxt  = cnt_q + 1'b1;
    end

    // Frame and lane strobes derived from the counter and mode.
    always_comb begin
        frame_start = rise_en && (!started_q || (cnt_q == last_cnt));
        rx_shift    = rise_en && started_q && !frame_start &&
                      ((mode_q == RATE_FULL) || cnt_q[0]);
        tx_sample   = fall_en && started_q;
        tx_done     = tx_sample && (cnt_q[POS_W-1:0] == POS_LAST);
    end

    // Divide-by-two bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= ~bclk_q;
    end

    // Frame counter, mode capture and strobe, all on bit-clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            cnt_q     <= '0;
            mode_q    <= RATE_FULL;
            wclk_q    <= 1'b0;
        end else if (rise_en) begin
            if (frame_start) begin
                started_q <= 1'b1;
                cnt_q     <= '0;
                mode_q    <= cwf_rate_t'(rate_half);
                wclk_q    <= 1'b1;
            end else begin
                cnt_q  <= cnt_nxt;
                wclk_q <= (cnt_nxt < high_lim);
            end
        end
    end

    assign bit_clk = bclk_q;
    assign wclk    = wclk_q;
endmodule

// File: rtl/cwf_tx_lane.sv
// Transmit lane assembler for one channel: shifts in the high-byte and
// low-byte lines MSB first on bit-clock falls and presents the finished
// word with a one-cycle strobe, converting offset binary if selected.
// Assumes: the timing block marks the eighth bit pair with tx_done.
module cwf_tx_lane #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sample,
    input  logic              tx_done,
    input  logic              fmt_ob,
    input  logic              lane_hi,
    input  logic              lane_lo,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int HALF_W = WORD_W / 2;

    logic [HALF_W-1:0] hi_sr;
    logic [HALF_W-1:0] lo_sr;
    logic [HALF_W-1:0] hi_nxt;
    logic [HALF_W-1:0] lo_nxt;
    logic [WORD_W-1:0] joined;

    // Next shift contents, including the bit sampled on this edge.
    always_comb begin
        hi_nxt = {hi_sr[HALF_W-2:0], lane_hi};
        lo_nxt = {lo_sr[HALF_W-2:0], lane_lo};
        joined = {hi_nxt, lo_nxt};
    end

    // Byte shift registers, advanced on every sample enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_sr <= '0;
            lo_sr <= '0;
        end else if (tx_sample) begin
            hi_sr <= hi_nxt;
            lo_sr <= lo_nxt;
        end
    end

    // Word output register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= tx_done;
            if (tx_done) word <= {joined[WORD_W-1] ^ fmt_ob, joined[WORD_W-2:0]};
        end
    end
endmodule

// File: rtl/cwf_rx_lane.sv
// Receive lane serialiser for one channel: loads the ADC word at frame
// start (converting to offset binary if selected) and shifts it out MSB
// first whenever the timing block issues a shift enable.
// Assumes: frame_start and rx_shift are never high together.
module cwf_rx_lane #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              rx_shift,
    input  logic              fmt_ob,
    input  logic [WORD_W-1:0] adc_word,
    output logic              rx_bit
);
    logic [WORD_W-1:0] sr_q;

    // Load at frame start, shift left on each shift enable.
    always_ff @(posedge clk) begin
        if (!rst_n)           sr_q <= '0;
        else if (frame_start) sr_q <= {adc_word[WORD_W-1] ^ fmt_ob, adc_word[WORD_W-2:0]};
        else if (rx_shift)    sr_q <= {sr_q[WORD_W-2:0], 1'b0};
    end

    assign rx_bit = sr_q[WORD_W-1];
endmodule

// File: rtl/conv_word_framer.sv
// Top of the multichannel converter word framer. One timing block serves
// all channels; a generate loop builds one transmit assembler and one
// receive serialiser per channel.
// Assumes: single master clock domain; synchronous active-low reset.
module conv_word_framer
    import cwf_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int WORD_W = CWF_WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rate_half,
    input  logic                  rx_fmt_ob,
    input  logic                  tx_fmt_ob,
    input  logic [2*NCH-1:0]      tx_lane,
    input  logic [WORD_W*NCH-1:0] adc_words,
    output logic                  bit_clk,
    output logic                  wclk,
    output logic [NCH-1:0]        rx_lane,
    output logic [WORD_W*NCH-1:0] dac_words,
    output logic                  dac_valid
);
    logic           frame_start;
    logic           rx_shift;
    logic           tx_sample;
    logic           tx_done;
    logic [NCH-1:0] valid_ch;

    cwf_timing #(.WORD_W(WORD_W)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_half  (rate_half),
        .bit_clk    (bit_clk),
        .wclk       (wclk),
        .frame_start(frame_start),
        .rx_shift   (rx_shift),
        .tx_sample  (tx_sample),
        .tx_done    (tx_done)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cwf_tx_lane #(.WORD_W(WORD_W)) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_sample(tx_sample),
            .tx_done  (tx_done),
            .fmt_ob   (tx_fmt_ob),
            .lane_hi  (tx_lane[2*c+1]),
            .lane_lo  (tx_lane[2*c]),
            .word     (dac_words[WORD_W*c +: WORD_W]),
            .valid    (valid_ch[c])
        );

        cwf_rx_lane #(.WORD_W(WORD_W)) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_start(frame_start),
            .rx_shift   (rx_shift),
            .fmt_ob     (rx_fmt_ob),
            .adc_word   (adc_words[WORD_W*c +: WORD_W]),
            .rx_bit     (rx_lane[c])
        );
    end

    // All channels complete together; channel 0 stands for the group.
    assign dac_valid = valid_ch[0];
endmodule

// File: rtl/cwf_chk.sv
// Port-level checker for the converter word framer, attached by bind.
// Assumes: synchronous active-low reset; armed_q blocks the first edge.
module cwf_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bit_clk,
    input logic           wclk,
    input logic [NCH-1:0] rx_lane,
    input logic           dac_valid
);
    logic armed_q;

    // Marks that at least one edge has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (bit_clk != $past(bit_clk)));

    // R3
    wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$stable(wclk)) |-> $rose(bit_clk));

    // R4
    rx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$stable(rx_lane)) |-> $rose(bit_clk));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    // R8
    valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && dac_valid) |-> $fell(bit_clk));
endmodule

bind conv_word_framer cwf_chk #(.NCH(NCH)) u_cwf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_clk  (bit_clk),
    .wclk     (wclk),
    .rx_lane  (rx_lane),
    .dac_valid(dac_valid)
);

// File: tb/conv_word_framer_test.sv
module conv_word_framer_test;
    localparam int NCH = 4;
    localparam int W   = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 rate_half = 1'b0;
    logic                 rx_fmt_ob = 1'b0;
    logic                 tx_fmt_ob = 1'b0;
    logic [2*NCH-1:0]     tx_lane = '0;
    logic [W*NCH-1:0]     adc_words = '0;
    logic                 bit_clk;
    logic                 wclk;
    logic [NCH-1:0]       rx_lane;
    logic [W*NCH-1:0]     dac_words;
    logic                 dac_valid;

    int checks = 0;
    int errors = 0;

    conv_word_framer #(.NCH(NCH), .WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .rate_half(rate_half),
        .rx_fmt_ob(rx_fmt_ob), .tx_fmt_ob(tx_fmt_ob), .tx_lane(tx_lane),
        .adc_words(adc_words), .bit_clk(bit_clk), .wclk(wclk),
        .rx_lane(rx_lane), .dac_words(dac_words), .dac_valid(dac_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] flip_msb(input logic [W-1:0] v, input logic ob);
        return {v[W-1] ^ ob, v[W-2:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reset for a few clocks; leaves the bench at a negedge with rst_n high.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(bit_clk == 0 && wclk == 0 && rx_lane == 0 && dac_valid == 0,
            "R1 reset state", {bit_clk, wclk, rx_lane, dac_valid}, 0);
        rst_n = 1'b1;
    endtask

    // Runs up to nbits bit-clock cycles of one frame from a negedge.
    task automatic run_frame(input bit half, input bit rxob, input bit txob,
                             input bit mid_change, input int nbits);
        logic [W*NCH-1:0] adc_cap;
        logic [W-1:0]     txw [NCH][4];
        int               per;
        per = half ? 2*W : W;
        rate_half = half;
        rx_fmt_ob = rxob;
        tx_fmt_ob = txob;
        for (int c = 0; c < NCH; c++) begin
            adc_words[W*c +: W] = W'($urandom);
            for (int w = 0; w < 4; w++) txw[c][w] = W'($urandom);
        end
        adc_cap = adc_words;
        for (int k = 0; k < nbits && k < per; k++) begin
            int j = k % 8;
            int w = k / 8;
            int idx = half ? (W-1 - k/2) : (W-1 - k);
            logic [NCH-1:0] exp_rx;
            logic [W*NCH-1:0] exp_dac;
            for (int c = 0; c < NCH; c++) begin
                tx_lane[2*c+1] = txw[c][w][15-j];
                tx_lane[2*c]   = txw[c][w][7-j];
            end
            if (mid_change && k == 3) begin
                // R6 R7: captured only at frame start
                adc_words = {$urandom, $urandom};
                rate_half = ~half;
                rx_fmt_ob = ~rxob;
            end
            @(posedge clk); @(negedge clk);
            for (int c = 0; c < NCH; c++)
                exp_rx[c] = flip_msb(adc_cap[W*c +: W], rxob)[idx];
            chk(bit_clk == 1'b1, "R1 bit clock high", 64'(bit_clk), 1);
            chk(wclk == (k < per/2), k == 0 ? "R2 frame start strobe" : "R3 strobe shape",
                64'(wclk), 64'(k < per/2));
            chk(rx_lane == exp_rx, half ? "R5 half-rate lane" : (k == 0 ? "R2 first bit" : "R4 full-rate lane"),
                64'(rx_lane), 64'(exp_rx));
            chk(dac_valid == 1'b0, "R9 single-cycle valid", 64'(dac_valid), 0);
            @(posedge clk); @(negedge clk);
            if (j == 7) begin
                for (int c = 0; c < NCH; c++)
                    exp_dac[W*c +: W] = flip_msb(txw[c][w], txob);
                chk(dac_valid == 1'b1, "R9 valid strobe", 64'(dac_valid), 1);
                chk(dac_words == exp_dac, txob ? "R11 R12 offset tx word" : "R8 R12 tx word",
                    dac_words, exp_dac);
            end else begin
                chk(dac_valid == 1'b0, "R8 no early valid", 64'(dac_valid), 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20250));
        do_reset();
        // Directed corners: plain full rate, half rate, formats, mid-frame changes.
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 99);
        run_frame(1'b1, 1'b0, 1'b0, 1'b0, 99);
        run_frame(1'b0, 1'b1, 1'b1, 1'b0, 99);   // R10 R11
        run_frame(1'b1, 1'b1, 1'b0, 1'b1, 99);   // R6 R7
        run_frame(1'b0, 1'b0, 1'b1, 1'b1, 99);   // R6 R7
        // Reset in the middle of a frame, then realign (R2).
        run_frame(1'b1, 1'b0, 1'b0, 1'b0, 11);
        do_reset();
        run_frame(1'b1, 1'b1, 1'b1, 1'b0, 99);
        // Random frames.
        for (int f = 0; f < 24; f++)
            run_frame(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 99);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule